// File: doc/BRIEF.md
# Prioritised Interrupt Controller Core

This block gathers interrupt requests from eight devices and hands them to a processor one at a time. Each request line passes a per-line mask. An unmasked request is latched into a pending register. A fixed-priority resolver picks the most urgent pending line. That line moves into an in-service register, and a single interrupt output tells the processor that work is waiting.

The processor talks to the block through two byte-wide port addresses:

- **Mask port (0x21).** The processor reads and writes the whole mask here. This lets it read-modify-write a single line's mask bit.
- **Command port (0x20).** A read returns the in-service register. Writing the end-of-interrupt code to this port retires the current service.

A line stays in service until the processor retires it explicitly. Higher-priority lines may nest on top of a line that is already in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line whose mask bit is 1 is never captured as pending, so it can never reach service or raise the interrupt output, even if the line is later unmasked.
- R2: A request on an unmasked line is remembered in the pending register after the line drops, and it stays there until it is moved into service.
- R3: Priority is fixed, with line 0 the most urgent and line 7 the least. When several eligible requests are pending, only the lowest-numbered one is promoted in a given cycle.
- R4: A pending request is promoted only when no in-service bit is set at its own position or at any lower-numbered position. So a more urgent request preempts a less urgent one that is in service, and a less urgent request waits.
- R5: Promotion sets the chosen line's in-service bit and clears its pending bit on the same clock edge. The interrupt output is 1 exactly while the in-service register is non-zero.
- R6: At port address 0x21 the full 8-bit mask is written and read back, with bit n masking line n. Clearing one bit by read-modify-write (AND with 0xEF clears line 4) leaves the other seven bits unchanged.
- R7: Writing 0x20 to port address 0x20 clears the lowest-numbered set in-service bit. Any other value written to port 0x20 leaves the in-service register unchanged.
- R8: A read of port address 0x20 returns the in-service register, with bit n for line n. A read of any address other than 0x20 or 0x21 returns 0.
- R9: A request that is already pending but whose mask bit has since been set to 1 is not promoted. It is promoted once its mask bit returns to 0.
- R10: Reset sets the mask to 0xFF, clears the pending and in-service registers, and drives the interrupt output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Device request lines, bit n is line n |
| busAddr | input | 8 | Port address for reads and writes |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| intOut | output | 1 | Interrupt request to the processor |

## Verification
The resolver is driven with several request patterns:

- **Single unmasked lines** check basic capture and service.
- **Two lines pulsed together** (4 and 5; 0 and 7) separate the winner from the line left pending.
- **A more urgent line arriving during service** separates preemption from blocking.
- **A less urgent line arriving during service** does the same from the other side.
- **All eight lines raised with only line 4 unmasked** shows that masked lines are dropped, not deferred.
- **A captured request masked afterwards** shows that the resolver looks at the current mask as well as the pending bits.

The remaining cases cover retirement:

- **A non-matching command byte** must leave service untouched.
- **Back-to-back end-of-interrupt commands** must retire nested services from the most urgent outward, each one releasing the next waiting request.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES = 8;

  // Strobes the control side hands to the register side each cycle.
  typedef struct packed {
    logic             maskLoad;  // load the mask from the write data
    logic [LINES-1:0] grant;     // one-hot line moving pending -> in service
    logic [LINES-1:0] retire;    // one-hot in-service bit being cleared
  } picStrobes_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h21,
  parameter logic [LINES-1:0]  EOI_CODE  = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [LINES-1:0]  busWdata,
  input  logic [LINES-1:0]  pendVec,
  input  logic [LINES-1:0]  isrVec,
  input  logic [LINES-1:0]  maskVec,
  output picStrobes_t       strobes
);
  logic [LINES-1:0] eligible;
  logic [LINES-1:0] bestReq;
  logic [LINES-1:0] topService;
  logic             eoiCmd;

  // Lowest set bit of a vector, isolated as one-hot; line 0 is most urgent.
  always_comb begin
    eligible   = pendVec & ~maskVec;
    bestReq    = eligible & (~eligible + 1'b1);
    topService = isrVec & (~isrVec + 1'b1);
  end

  assign eoiCmd = busWr && (busAddr == CMD_ADDR) && (busWdata == EOI_CODE);

  always_comb begin
    strobes          = '0;
    strobes.maskLoad = busWr && (busAddr == MASK_ADDR);
    // One-hot vectors compare like bit positions: smaller value = more urgent.
    if (bestReq != '0 && (topService == '0 || bestReq < topService))
      strobes.grant = bestReq;
    if (eoiCmd)
      strobes.retire = topService;
  end

  // R7: an end-of-interrupt never adds to the number of lines in service
  // (one retired, at most one promoted).
  a_r7_eoi_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    (eoiCmd && isrVec != '0) |=> ($countones(isrVec) <= $countones($past(isrVec))));

  // R3: at most one line is promoted per cycle.
  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.grant));
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LINES-1:0]  busWdata,
  input  picStrobes_t       strobes,
  output logic [LINES-1:0]  pendVec,
  output logic [LINES-1:0]  isrVec,
  output logic [LINES-1:0]  maskVec,
  output logic [LINES-1:0]  busRdata,
  output logic              intOut
);
  always_ff @(posedge clk) begin
    if (!rstN)                 maskVec <= '1;
    else if (strobes.maskLoad) maskVec <= busWdata;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [LINES-1:0] UP_TO_ME = LINES'((2 << i) - 1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendVec[i] <= 1'b0;
        isrVec[i]  <= 1'b0;
      end else begin
        pendVec[i] <= (pendVec[i] | (irqIn[i] & ~maskVec[i])) & ~strobes.grant[i];
        isrVec[i]  <= (isrVec[i] & ~strobes.retire[i]) | strobes.grant[i];
      end
    end

    // R1: a line only becomes pending while its mask bit was clear.
    a_r1_masked_stays_out: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendVec[i]) |-> !$past(maskVec[i]));
    // R2/R5: a pending bit leaves only by entering service.
    a_r2_pend_until_service: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendVec[i]) |-> isrVec[i]);
    // R5: a new in-service bit was pending the cycle before.
    a_r5_service_from_pend: assert property (@(posedge clk) disable iff (!rstN)
      $rose(isrVec[i]) |-> $past(pendVec[i]));
    // R4: nothing at this level or above was in service when it was promoted.
    a_r4_no_block_violation: assert property (@(posedge clk) disable iff (!rstN)
      $rose(isrVec[i]) |-> (($past(isrVec) & UP_TO_ME) == '0));
  end

  assign intOut = |isrVec;

  always_comb begin
    if (busAddr == MASK_ADDR)     busRdata = maskVec;
    else if (busAddr == CMD_ADDR) busRdata = isrVec;
    else                          busRdata = '0;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h21,
  parameter logic [LINES-1:0]  EOI_CODE  = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [LINES-1:0]  busWdata,
  output logic [LINES-1:0]  busRdata,
  output logic              intOut
);
  picStrobes_t      strobes;
  logic [LINES-1:0] pendVec;
  logic [LINES-1:0] isrVec;
  logic [LINES-1:0] maskVec;

  pic_ctrl #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .MASK_ADDR(MASK_ADDR), .EOI_CODE(EOI_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .pendVec(pendVec), .isrVec(isrVec), .maskVec(maskVec), .strobes(strobes)
  );

  pic_datapath #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr), .busWdata(busWdata),
    .strobes(strobes), .pendVec(pendVec), .isrVec(isrVec), .maskVec(maskVec),
    .busRdata(busRdata), .intOut(intOut)
  );
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] irqIn;
  logic [7:0] busAddr;
  logic       busWr;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       intOut;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .intOut(intOut)
  );

  localparam logic [1:0] K_IRQ = 2'd0, K_MASK = 2'd1, K_CMD = 2'd2;
  // {kind, value, expected in-service, expected intOut, requirement number}
  localparam int NV = 21;
  localparam logic [22:0] VEC [NV] = '{
    {K_IRQ,  8'h08, 8'h00, 1'b0, 4'd1},  // R1 masked line (mask EF) dropped
    {K_MASK, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 unmasking shows nothing captured
    {K_IRQ,  8'h30, 8'h10, 1'b1, 4'd3},  // R3 line 4 beats line 5
    {K_IRQ,  8'h04, 8'h14, 1'b1, 4'd4},  // R4 line 2 preempts line 4
    {K_CMD,  8'h20, 8'h10, 1'b1, 4'd7},  // R7 retires line 2 first
    {K_CMD,  8'h20, 8'h20, 1'b1, 4'd2},  // R2 line 5 waited, now served
    {K_CMD,  8'h11, 8'h20, 1'b1, 4'd7},  // R7 other command byte ignored
    {K_CMD,  8'h20, 8'h00, 1'b0, 4'd5},  // R5 output drops when empty
    {K_MASK, 8'hEF, 8'h00, 1'b0, 4'd6},
    {K_IRQ,  8'hFF, 8'h10, 1'b1, 4'd1},  // R1 only line 4 open
    {K_CMD,  8'h20, 8'h00, 1'b0, 4'd7},
    {K_MASK, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 masked lines were not deferred
    {K_IRQ,  8'h81, 8'h01, 1'b1, 4'd3},  // R3 line 0 beats line 7
    {K_CMD,  8'h20, 8'h80, 1'b1, 4'd2},  // R2 line 7 released
    {K_CMD,  8'h20, 8'h00, 1'b0, 4'd7},
    {K_IRQ,  8'h01, 8'h01, 1'b1, 4'd5},
    {K_IRQ,  8'h08, 8'h01, 1'b1, 4'd4},  // R4 less urgent line waits
    {K_MASK, 8'h08, 8'h01, 1'b1, 4'd9},
    {K_CMD,  8'h20, 8'h00, 1'b0, 4'd9},  // R9 masked pending line held back
    {K_MASK, 8'h00, 8'h08, 1'b1, 4'd9},  // R9 unmasked, now served
    {K_CMD,  8'h20, 8'h00, 1'b0, 4'd7}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic readPort(input logic [7:0] addr, output logic [7:0] val);
    busAddr = addr;
    #1 val = busRdata;
  endtask

  task automatic writePort(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stimulus
    logic [7:0] rd;
    rstN = 1'b0; irqIn = '0; busAddr = '0; busWr = 1'b0; busWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    readPort(8'h20, rd);  check(10, rd, 8'h00, "in-service after reset");
    readPort(8'h21, rd);  check(10, rd, 8'hFF, "mask after reset");
    check(10, {7'd0, intOut}, 8'h00, "intOut after reset");
    // R8 unused address reads zero
    readPort(8'h22, rd);  check(8, rd, 8'h00, "unused address read");
    // R6 read-modify-write clears only bit 4
    readPort(8'h21, rd);
    writePort(8'h21, rd & 8'hEF);
    readPort(8'h21, rd);  check(6, rd, 8'hEF, "mask after clearing bit 4");

    for (int v = 0; v < NV; v++) begin
      logic [1:0] kind;
      logic [7:0] val;
      kind = VEC[v][22:21];
      val  = VEC[v][20:13];
      if (kind == K_IRQ) begin
        @(negedge clk); irqIn = val;
        @(negedge clk); irqIn = '0;
      end else if (kind == K_MASK) begin
        writePort(8'h21, val);
      end else begin
        writePort(8'h20, val);
      end
      settle();
      readPort(8'h20, rd);  // R8 in-service register read back at 0x20
      check(int'(VEC[v][3:0]), rd, VEC[v][12:5], $sformatf("in-service, vector %0d", v));
      check(int'(VEC[v][3:0]), {7'd0, intOut}, {7'd0, VEC[v][4]}, $sformatf("intOut, vector %0d", v));
      if (kind == K_MASK) begin
        readPort(8'h21, rd);
        check(6, rd, val, $sformatf("mask readback, vector %0d", v));
      end
    end

    // R10 reset while a line is in service
    @(negedge clk); irqIn = 8'h02;
    @(negedge clk); irqIn = '0;
    settle();
    readPort(8'h20, rd);  check(5, rd, 8'h02, "line 1 in service before reset");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readPort(8'h20, rd);  check(10, rd, 8'h00, "in-service cleared by reset");
    readPort(8'h21, rd);  check(10, rd, 8'hFF, "mask restored by reset");
    check(10, {7'd0, intOut}, 8'h00, "intOut cleared by reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule